// File: doc/BRIEF.md
# Serial Transmitter with Baud-Gated Pad Drive

This block serialises bytes onto a single line in the common asynchronous framing: one low start bit, eight data bits least significant first, then one high stop bit. It sits behind a peripheral register front end. Two enables, a 16-bit baud divisor, a byte write channel and a status-read strobe come in. The serial line, a pad output-enable, a holding-register-empty flag and a transmission-complete flag go out.

The pad drive is not slaved to the enable bits. It follows the baud generator. When transmission is switched on, the line stays undriven until the first full bit period has elapsed, and then drives high. A whole frame time of idle-high is sent before the first data frame. When transmission is switched off, drive is held for about half a bit and then released. Divisors outside the usable range stop the baud generator, so the pad is never driven. While the pad is undriven, the data output still presents a defined high level.

Bytes enter through a valid/ready channel into one holding register. `wr_ready` is high only while the transmitter is enabled and the holding register is empty. A byte transfers on any rising clock edge where `wr_valid` and `wr_ready` are both high. A producer facing low `wr_ready` keeps `wr_valid` and `wr_data` steady until the transfer. No byte is dropped or overwritten.

Top module: `txo_uart_tx`

## Requirements
- R1: The transmitter is active only while both `unit_en` and `tx_en` are 1. While `unit_en` is 0, `wr_ready` is 0, and `txd_oe` is 0 after the next clock edge, even if it was 1.
- R2: The bit period P, in clocks, equals the divisor (a 12-bit mantissa times 16 plus a 4-bit fraction) for divisors 16 to 0xFFF7. For divisors 8 to 15, P is the divisor times 4096, so a divisor of 8 gives P = 0x8000.
- R3: `txd_oe` rises on the P-th rising edge counted from the first edge that samples the transmitter active (that edge counts as 1). Before that, and whenever `txd_oe` is 0, `txd` reads 1.
- R4: After the drive turns on, the line is held high for ten bit periods (one idle frame) before the first start bit can begin.
- R5: A frame is a start bit at 0, then data bits 0 through 7 in ascending order, then a stop bit at 1. Each bit lasts P clocks.
- R6: When `tx_en` is cleared with no frame in progress, `txd_oe` stays 1 through edge floor(P/2) and is 0 from edge floor(P/2)+1. The edge that first samples `tx_en` at 0 counts as 1. A frame in progress completes before this release starts.
- R7: With a divisor of 7 or less, no baud events occur: `txd_oe` stays 0 and `txd` stays 1 after enabling.
- R8: With a divisor of 0xFFF8 or more, no baud events occur: `txd_oe` stays 0 after enabling.
- R9: `tx_empty` is 1 when the holding register is empty. It goes to 0 on the edge that accepts a byte, and back to 1 on the edge that moves the byte into the shifter. The move happens at the start-bit boundary.
- R10: `tx_done` is 0 after reset and sets at the end of a stop bit when no byte is waiting. It clears on the edge that accepts a byte, but only if `stat_rd` was seen while `tx_done` was 1 before that edge. A byte written without that read leaves `tx_done` at 1.
- R11: If a byte is waiting when a stop bit ends, its start bit begins at that same edge, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Whole-unit enable |
| tx_en | input | 1 | Transmit enable |
| baud_div | input | 16 | Baud divisor (mantissa in [15:4], fraction in [3:0]) |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_ready | output | 1 | Holding register can take a byte |
| wr_data | input | 8 | Byte to send |
| stat_rd | input | 1 | Status-read strobe, one clock per read |
| txd | output | 1 | Serial data, reads 1 when undriven |
| txd_oe | output | 1 | Pad output-enable |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |

## Verification
The bench counts clock edges from the moment of enable and of disable. It requires the pad drive to appear exactly one bit period later and to release exactly half a bit later. A design that drives straight from the enable bit, or that releases at once, fails those edges. It samples every bit of frames sent at several divisors, including an odd one, so a frame with the wrong bit order, a missing idle frame or a bit period off by one is caught mid-bit. Divisors at 7, 8, 0xFFF8 and 0xFFFF are checked: a generator that ticks at any of these, or treats 8 as a period of 8 clocks, is reported. Back-to-back bytes, complete-flag clearing with and without a prior status read, and a unit-enable drop while driving are also checked.

// File: rtl/txo_pkg.sv
`timescale 1ns/1ps
package txo_pkg;
  typedef enum logic [2:0] {
    S_OFF, S_WAKE, S_PRE, S_IDLE, S_START, S_DATA, S_STOP, S_DRAIN
  } tx_state_e;
endpackage

// File: rtl/txo_baud_gen.sv
`timescale 1ns/1ps
module txo_baud_gen #(
  parameter int DIV_W      = 16,
  parameter int DIV_MIN    = 8,
  parameter int DIV_MAX    = 65527,
  parameter int SLOW_LIMIT = 16,
  parameter int SLOW_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             div_ok,
  output logic             tick,
  output logic             half_tick
);
  localparam int PER_W = DIV_W + SLOW_SHIFT;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] cnt;
  logic             run;

  // Divisors below SLOW_LIMIT have a zero mantissa and stretch to a very long period
  always_comb begin
    div_ok = (div >= DIV_W'(DIV_MIN)) && (div <= DIV_W'(DIV_MAX));
    if (div < DIV_W'(SLOW_LIMIT)) period = PER_W'(div) << SLOW_SHIFT;
    else                           period = PER_W'(div);
    run       = run_req && div_ok;
    tick      = run && (cnt >= period - PER_W'(1));
    half_tick = run && (cnt == (period >> 1) - PER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt <= '0;
    else if (!run || restart || tick)   cnt <= '0;
    else                                cnt <= cnt + PER_W'(1);
  end

  // R2: the counter wraps to zero after every bit boundary
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/txo_hold_status.sv
`timescale 1ns/1ps
module txo_hold_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              stat_rd,
  input  logic              frame_end,
  output logic              wr_ready,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_done
);
  logic accept;
  logic armed;

  assign wr_ready = active && !hold_full;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  // Complete flag: a read seen while set arms the clear, and the next accepted byte clears it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      armed   <= 1'b0;
    end else if (frame_end) begin
      tx_done <= 1'b1;
      armed   <= 1'b0;
    end else if (accept && armed) begin
      tx_done <= 1'b0;
      armed   <= 1'b0;
    end else if (stat_rd && tx_done) begin
      armed   <= 1'b1;
    end
  end

  // R9: the holding register only empties into the shifter
  a_r9_hold_empties_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_full) |-> $past(load));
  // R10: the complete flag only rises at a frame end
  a_r10_done_from_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(frame_end));
endmodule

// File: rtl/txo_frame_fsm.sv
`timescale 1ns/1ps
module txo_frame_fsm
  import txo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              active,
  input  logic              tick,
  input  logic              half_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              load,
  output logic              restart,
  output logic              frame_end,
  output logic              txd,
  output logic              txd_oe
);
  localparam int PRE_BITS = DATA_W + 2;
  localparam int BITS_W   = $clog2(PRE_BITS);

  tx_state_e         state, nstate;
  logic              noe;
  logic [DATA_W-1:0] shift, nshift;
  logic [BITS_W-1:0] bits, nbits;

  always_comb begin
    nstate    = state;
    noe       = txd_oe;
    nshift    = shift;
    nbits     = bits;
    load      = 1'b0;
    restart   = 1'b0;
    frame_end = 1'b0;
    if (!unit_en) begin
      nstate = S_OFF;
      noe    = 1'b0;
    end else begin
      unique case (state)
        S_OFF:   if (active) nstate = S_WAKE;
        S_WAKE: begin
          if (!active) nstate = S_OFF;
          else if (tick) begin
            noe    = 1'b1;
            nstate = S_PRE;
            nbits  = '0;
          end
        end
        S_PRE: begin
          if (!active) begin
            nstate  = S_DRAIN;
            restart = 1'b1;
          end else if (tick) begin
            if (bits == BITS_W'(PRE_BITS - 1)) begin
              if (hold_full) begin
                load   = 1'b1;
                nshift = hold_data;
                nstate = S_START;
              end else begin
                nstate = S_IDLE;
              end
            end else begin
              nbits = bits + BITS_W'(1);
            end
          end
        end
        S_IDLE: begin
          if (!active) begin
            nstate  = S_DRAIN;
            restart = 1'b1;
          end else if (hold_full) begin
            load    = 1'b1;
            restart = 1'b1;
            nshift  = hold_data;
            nstate  = S_START;
          end
        end
        S_START: if (tick) begin
          nstate = S_DATA;
          nbits  = '0;
        end
        S_DATA: if (tick) begin
          nshift = shift >> 1;
          if (bits == BITS_W'(DATA_W - 1)) nstate = S_STOP;
          else                             nbits  = bits + BITS_W'(1);
        end
        S_STOP: if (tick) begin
          if (active && hold_full) begin
            load   = 1'b1;
            nshift = hold_data;
            nstate = S_START;
          end else begin
            frame_end = 1'b1;
            if (active) nstate = S_IDLE;
            else begin
              nstate  = S_DRAIN;
              restart = 1'b1;
            end
          end
        end
        S_DRAIN: if (half_tick) begin
          noe    = 1'b0;
          nstate = S_OFF;
        end
        default: nstate = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_OFF;
      txd_oe <= 1'b0;
      shift  <= '0;
      bits   <= '0;
    end else begin
      state  <= nstate;
      txd_oe <= noe;
      shift  <= nshift;
      bits   <= nbits;
    end
  end

  always_comb begin
    if (!txd_oe)                txd = 1'b1;
    else if (state == S_START)  txd = 1'b0;
    else if (state == S_DATA)   txd = shift[0];
    else                        txd = 1'b1;
  end

  // R3: drive turns on only at a bit boundary
  a_r3_oe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_oe) |-> $past(tick));
  // R6: with the unit still on, drive releases only at a mid-bit event
  a_r6_oe_off_half: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd_oe) && $past(unit_en)) |-> $past(half_tick));
  // R1: unit enable low removes drive
  a_r1_unit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> !txd_oe);
endmodule

// File: rtl/txo_uart_tx.sv
`timescale 1ns/1ps
module txo_uart_tx #(
  parameter int DIV_W      = 16,
  parameter int DATA_W     = 8,
  parameter int DIV_MIN    = 8,
  parameter int DIV_MAX    = 65527,
  parameter int SLOW_LIMIT = 16,
  parameter int SLOW_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              txd,
  output logic              txd_oe,
  output logic              tx_empty,
  output logic              tx_done
);
  logic              active;
  logic              div_ok, tick, half_tick, restart;
  logic              load, frame_end, hold_full;
  logic [DATA_W-1:0] hold_data;

  assign active   = unit_en && tx_en;
  assign tx_empty = !hold_full;

  txo_baud_gen #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
    .SLOW_LIMIT(SLOW_LIMIT), .SLOW_SHIFT(SLOW_SHIFT)
  ) u_baud (
    .clk(clk), .rst_n(rst_n),
    .run_req(unit_en && (active || txd_oe)),
    .restart(restart), .div(baud_div),
    .div_ok(div_ok), .tick(tick), .half_tick(half_tick)
  );

  txo_hold_status #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .active(active),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .load(load), .stat_rd(stat_rd), .frame_end(frame_end),
    .wr_ready(wr_ready), .hold_full(hold_full),
    .hold_data(hold_data), .tx_done(tx_done)
  );

  txo_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .active(active),
    .tick(tick), .half_tick(half_tick),
    .hold_full(hold_full), .hold_data(hold_data),
    .load(load), .restart(restart), .frame_end(frame_end),
    .txd(txd), .txd_oe(txd_oe)
  );

  // R7, R8: an unusable divisor freezes the pad drive while the unit is on
  a_r7_r8_bad_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && !div_ok) |=> $stable(txd_oe));
endmodule

// File: tb/txo_uart_tx_test.sv
`timescale 1ns/1ps
module txo_uart_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unit_en = 1'b0, tx_en = 1'b0, wr_valid = 1'b0, stat_rd = 1'b0;
  logic [15:0] baud_div = 16'd16;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_ready, txd, txd_oe, tx_empty, tx_done;

  int n_chk = 0;
  int n_err = 0;
  int e = 0;

  always #2 clk = ~clk;

  txo_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tx_en(tx_en),
    .baud_div(baud_div), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .stat_rd(stat_rd), .txd(txd), .txd_oe(txd_oe),
    .tx_empty(tx_empty), .tx_done(tx_done)
  );

  // divisor, byte
  localparam logic [23:0] VEC [4] = '{
    {16'd16, 8'h55}, {16'd35, 8'hA3}, {16'd20, 8'h00}, {16'd17, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, e);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      e++;
    end
  endtask

  task automatic go(input int t);
    while (e < t) step(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; unit_en = 1'b0; tx_en = 1'b0; wr_valid = 1'b0; stat_rd = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  function automatic int per(input logic [15:0] d);
    return (d < 16) ? int'(d) * 4096 : int'(d);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p;
    logic [7:0] b;
    @(negedge clk);
    do_reset();
    chk("R1 reset oe", txd_oe, 0);
    chk("R3 reset txd", txd, 1);
    chk("R9 reset empty", tx_empty, 1);
    chk("R10 reset done", tx_done, 0);
    chk("R1 reset ready", wr_ready, 0);

    for (int v = 0; v < 4; v++) begin
      do_reset();
      baud_div = VEC[v][23:8];
      b = VEC[v][7:0];
      p = per(baud_div);
      unit_en = 1'b1; tx_en = 1'b1; wr_valid = 1'b1; wr_data = b; e = 0;
      step(1);
      wr_valid = 1'b0;
      chk("R9 empty after accept", tx_empty, 0);
      go(p - 1);
      chk("R3 undriven before period", txd_oe, 0);
      chk("R3 idle high undriven", txd, 1);
      go(p);
      chk("R3 drive after period", txd_oe, 1);
      go(6 * p);
      chk("R4 preamble high", txd, 1);
      go(11 * p - 1);
      chk("R4 preamble end high", txd, 1);
      chk("R9 still full", tx_empty, 0);
      go(11 * p);
      chk("R9 empty at load", tx_empty, 1);
      go(11 * p + p / 2);
      chk("R5 start bit", txd, 0);
      for (int k = 0; k < 8; k++) begin
        go(12 * p + k * p + p / 2);
        chk("R5 data bit", txd, b[k]);
      end
      go(20 * p + p / 2);
      chk("R5 stop bit", txd, 1);
      go(21 * p - 1);
      chk("R10 done before stop end", tx_done, 0);
      go(21 * p);
      chk("R10 done at stop end", tx_done, 1);
      tx_en = 1'b0; e = 0;
      go(p / 2);
      chk("R6 drive held", txd_oe, 1);
      go(p / 2 + 1);
      chk("R6 drive released", txd_oe, 0);
    end

    // R1: unit enable gating
    do_reset();
    baud_div = 16'd16; tx_en = 1'b1; wr_valid = 1'b1; wr_data = 8'h12; e = 0;
    step(1);
    chk("R1 ready low with unit off", wr_ready, 0);
    chk("R1 no accept with unit off", tx_empty, 1);
    wr_valid = 1'b0;
    go(50);
    chk("R1 no drive with unit off", txd_oe, 0);
    unit_en = 1'b1; e = 0;
    go(16);
    chk("R1 drive with both on", txd_oe, 1);
    unit_en = 1'b0;
    step(1);
    chk("R1 unit off drops drive", txd_oe, 0);

    // R7: small divisor
    do_reset();
    baud_div = 16'd7; unit_en = 1'b1; tx_en = 1'b1; e = 0;
    go(2000);
    chk("R7 no drive div 7", txd_oe, 0);
    chk("R7 txd high div 7", txd, 1);

    // R8: large divisors
    do_reset();
    baud_div = 16'hFFF8; unit_en = 1'b1; tx_en = 1'b1; e = 0;
    go(2000);
    chk("R8 no drive div FFF8", txd_oe, 0);
    do_reset();
    baud_div = 16'hFFFF; unit_en = 1'b1; tx_en = 1'b1; e = 0;
    go(2000);
    chk("R8 no drive div FFFF", txd_oe, 0);

    // R2: divisor 8 gives 0x8000 clocks
    do_reset();
    baud_div = 16'd8; unit_en = 1'b1; tx_en = 1'b1; e = 0;
    go(32767);
    chk("R2 slow period not yet", txd_oe, 0);
    go(32768);
    chk("R2 slow period reached", txd_oe, 1);

    // R10 and R11: clearing the complete flag, back-to-back frames
    do_reset();
    baud_div = 16'd16; p = 16;
    unit_en = 1'b1; tx_en = 1'b1; wr_valid = 1'b1; wr_data = 8'h5A; e = 0;
    step(1);
    wr_valid = 1'b0;
    go(21 * p);
    chk("R10 done set", tx_done, 1);
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0; wr_valid = 1'b1; wr_data = 8'h3C; e = 0;
    step(1);
    wr_valid = 1'b0;
    chk("R10 read then write clears", tx_done, 0);
    step(1);
    chk("R9 moved to shifter", tx_empty, 1);
    wr_valid = 1'b1; wr_data = 8'hC3;
    step(1);
    wr_valid = 1'b0;
    chk("R9 second byte held", tx_empty, 0);
    go(2 + p / 2);
    chk("R5 first start", txd, 0);
    for (int k = 0; k < 8; k++) begin
      go(2 + p + k * p + p / 2);
      chk("R5 first frame bit", txd, logic'(k == 2 || k == 3 || k == 4 || k == 5));
    end
    go(2 + 10 * p - 1);
    chk("R11 first stop", txd, 1);
    go(2 + 10 * p + p / 2);
    chk("R11 second start no gap", txd, 0);
    chk("R10 no done between frames", tx_done, 0);
    for (int k = 0; k < 8; k++) begin
      go(2 + 11 * p + k * p + p / 2);
      chk("R11 second frame bit", txd, logic'(k == 0 || k == 1 || k == 6 || k == 7));
    end
    go(2 + 20 * p);
    chk("R10 done after second", tx_done, 1);
    wr_valid = 1'b1; wr_data = 8'h81;
    step(1);
    wr_valid = 1'b0;
    chk("R10 write without read keeps done", tx_done, 1);

    finish_run();
  end
endmodule